// File: doc/BRIEF.md
# Cascadable Wired Interrupt Aggregator

This block merges a bank of interrupt sources into one level-style interrupt line. Each source is synchronised to the block clock. It is then captured into a sticky cause bit, either on a rising edge or while the source is high. One global control bit selects which of the two applies, and it covers every source. A per-source mask selects which captured causes may drive the output. Software acknowledges a cause by writing zero to its bit.

The output is a plain level line, so it can feed a parent interrupt controller directly. It can also drive one source input of another instance of the same block, which builds a cascade. Software reaches the block through a small APB-style slave port. The port holds three 32-bit registers: cause at byte offset 0x00, mask at 0x10 and control at 0x28. No wait states are inserted.

Top module: `intr_fabric_agg`

## Requirements
- R1: After reset, cause reads 0x00000000, mask reads 0xFFFFFFFF, control reads 0x00000000, and irq_o is low.
- R2: Mask (offset 0x10) is readable and writable. A mask bit of 1 blocks its source from irq_o, and a mask bit of 0 enables it.
- R3: Control (offset 0x28) stores bit 3 (1 = rising-edge mode, 0 = active-high level mode) and bit 5 (message path disabled). All other control bits read as zero.
- R4: In edge mode, a cause bit is set on a 0-to-1 transition of its synchronised source. It stays set after the source falls.
- R5: In level mode, a cause bit is set on every cycle its synchronised source is high. A clear written while the source is high does not stick.
- R6: A write to cause (offset 0x00) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: A set event in the same cycle as a software clear of that bit leaves the bit set.
- R8: Cause bits latch while their source is masked. Clearing the mask bit raises irq_o in the cycle after the mask write.
- R9: irq_o is high exactly when some cause bit is set whose mask bit is 0.
- R10: Reads from any offset other than 0x00, 0x10 and 0x28 return zero. Writes to such offsets change no register.
- R11: Sources pass through a two-flop synchroniser. A source that rises before clock edge 1 sets its cause bit at edge 3, and irq_o (if unmasked) is still low after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 8 | Byte offset |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid during a read access |
| src_i | input | 32 | Interrupt sources, asynchronous |
| irq_o | output | 1 | Aggregated level interrupt |

## Verification
The assertions assume three things about the bus. A write commits only in a cycle where select and enable are both high. Each access is a setup cycle followed by exactly one access cycle. The address is stable across the two cycles. The bench drives every access through one task that keeps this two-cycle pattern, with select deasserted between accesses. The sticky-cause and level-capture properties assume that sources change only between clock edges. The bench changes sources only on falling edges and holds them for whole cycles.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned OFF_W      = 8;
  localparam logic [OFF_W-1:0] OFF_CAUSE = 8'h00;
  localparam logic [OFF_W-1:0] OFF_MASK  = 8'h10;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 8'h28;
  localparam int unsigned CTRL_EDGE_BIT   = 3;
  localparam int unsigned CTRL_MSGOFF_BIT = 5;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic               edge_mode_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] cause_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic prev_q, cause_q, set_ev, keep;

    assign set_ev = edge_mode_i ? (sync_i[g] & ~prev_q) : sync_i[g];
    // write-zero clears; set event takes precedence
    assign keep   = cause_q & ~(clr_we_i & ~wdata_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        cause_q <= 1'b0;
      end else begin
        prev_q  <= sync_i[g];
        cause_q <= set_ev | keep;
      end
    end

    assign cause_o[g] = cause_q;
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [OFF_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  input  logic [NUM_SRC-1:0] cause_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               edge_mode_o,
  output logic               cause_we_o,
  output logic [NUM_SRC-1:0] cause_wdata_o
);
  logic wr_en, msg_off_q, edge_q;
  logic [NUM_SRC-1:0] mask_q;

  assign wr_en = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      edge_q    <= 1'b0;
      msg_off_q <= 1'b0;
    end else if (wr_en) begin
      if (paddr_i == OFF_MASK) mask_q <= pwdata_i[NUM_SRC-1:0];
      if (paddr_i == OFF_CTRL) begin
        edge_q    <= pwdata_i[CTRL_EDGE_BIT];
        msg_off_q <= pwdata_i[CTRL_MSGOFF_BIT];
      end
    end
  end

  assign cause_we_o    = wr_en && (paddr_i == OFF_CAUSE);
  assign cause_wdata_o = pwdata_i[NUM_SRC-1:0];
  assign mask_o        = mask_q;
  assign edge_mode_o   = edge_q;

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      unique case (paddr_i)
        OFF_CAUSE: prdata_o[NUM_SRC-1:0] = cause_i;
        OFF_MASK:  prdata_o[NUM_SRC-1:0] = mask_q;
        OFF_CTRL: begin
          prdata_o[CTRL_EDGE_BIT]   = edge_q;
          prdata_o[CTRL_MSGOFF_BIT] = msg_off_q;
        end
        default:   prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_fabric_agg.sv
module intr_fabric_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [OFF_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] sync_q, cause_q, mask_q, cause_wdata;
  logic               edge_mode, cause_we;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(sync_q)
  );

  irq_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_regif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .psel_i       (psel_i),
    .penable_i    (penable_i),
    .pwrite_i     (pwrite_i),
    .paddr_i      (paddr_i),
    .pwdata_i     (pwdata_i),
    .cause_i      (cause_q),
    .prdata_o     (prdata_o),
    .mask_o       (mask_q),
    .edge_mode_o  (edge_mode),
    .cause_we_o   (cause_we),
    .cause_wdata_o(cause_wdata)
  );

  irq_cause_bank #(.NUM_SRC(NUM_SRC)) i_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_q),
    .edge_mode_i(edge_mode),
    .clr_we_i   (cause_we),
    .wdata_i    (cause_wdata),
    .cause_o    (cause_q)
  );

  assign irq_o = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               psel_i,
  input logic               penable_i,
  input logic               pwrite_i,
  input logic [OFF_W-1:0]   paddr_i,
  input logic [NUM_SRC-1:0] sync_q,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               edge_mode,
  input logic               irq_o
);
  logic wr, wr_cause, wr_mask, wr_ctrl, wr_stray;
  assign wr       = psel_i & penable_i & pwrite_i;
  assign wr_cause = wr && paddr_i == OFF_CAUSE;
  assign wr_mask  = wr && paddr_i == OFF_MASK;
  assign wr_ctrl  = wr && paddr_i == OFF_CTRL;
  assign wr_stray = wr && !wr_cause && !wr_mask && !wr_ctrl;

  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));

  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(edge_mode));

  a_r4_edge_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode |=> ((cause_q & ~$past(cause_q) & ~$past(sync_q)) == '0));

  a_r5_level_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode && |sync_q) |=> ((cause_q & $past(sync_q)) == $past(sync_q)));

  a_r6_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  a_r9_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);

  a_r9_none_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q == '0) |-> !irq_o);

  a_r10_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stray |=> $stable(mask_q) && $stable(edge_mode));
endmodule

bind intr_fabric_agg irq_agg_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .sync_q   (sync_q),
  .cause_q  (cause_q),
  .mask_q   (mask_q),
  .edge_mode(edge_mode),
  .irq_o    (irq_o)
);

// File: tb/test_intr_fabric_agg.sv
module test_intr_fabric_agg;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata, src = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  intr_fabric_agg i_intr_fabric_agg (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .src_i(src), .irq_o(irq)
  );

  typedef struct packed {
    logic        edge_m;
    logic [31:0] pat;
    logic [31:0] msk;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 32'h0000_0001, 32'h0000_0000},
    '{1'b1, 32'h8000_0100, 32'h8000_0000},
    '{1'b1, 32'h0F0F_0000, 32'hFFFF_FFFF},
    '{1'b0, 32'h0000_0040, 32'h0000_0000},
    '{1'b0, 32'hA500_0003, 32'hA500_0000},
    '{1'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    rd(8'h00, d); chk("R1 cause", d, 32'h0);
    rd(8'h10, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3 control field readback
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R3 ctrl bits", d, 32'h28);
    wr(8'h28, 32'h20);        rd(8'h28, d); chk("R3 level+msgoff", d, 32'h20);

    // R2 mask readback
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); chk("R2 mask rw", d, 32'h1234_5678);

    // R10 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R10 rd 04", d, 32'h0);
    rd(8'h14, d); chk("R10 rd 14", d, 32'h0);
    rd(8'h10, d); chk("R10 mask kept", d, 32'h1234_5678);
    rd(8'h28, d); chk("R10 ctrl kept", d, 32'h20);

    // vector table: R4/R5/R9
    foreach (VECS[i]) begin
      wr(8'h28, VECS[i].edge_m ? 32'h28 : 32'h20);
      wr(8'h10, VECS[i].msk);
      @(negedge clk); src = VECS[i].pat;
      idle(5);
      if (VECS[i].edge_m) begin
        src = '0; idle(4);
      end
      rd(8'h00, d);
      chk(VECS[i].edge_m ? "R4 edge latch" : "R5 level latch", d, VECS[i].pat);
      chk("R9 irq", {31'b0, irq}, {31'b0, |(VECS[i].pat & ~VECS[i].msk)});
      src = '0; idle(4);
      wr(8'h00, 32'h0); rd(8'h00, d); chk("R6 clear all", d, 32'h0);
      chk("R9 irq idle", {31'b0, irq}, 32'h0);
    end

    // R6 write-one keeps
    wr(8'h28, 32'h28); wr(8'h10, 32'h0);
    @(negedge clk); src = 32'h0001_0001; idle(2); src = '0; idle(4);
    wr(8'h00, 32'hFFFF_0000); rd(8'h00, d); chk("R6 partial clear", d, 32'h0001_0000);
    wr(8'h00, 32'h0);

    // R5/R7 level clear while source high
    wr(8'h28, 32'h0);
    @(negedge clk); src = 32'h4; idle(5);
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R7 set beats clear", d, 32'h4);
    src = '0; idle(4);
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R5 clear after drop", d, 32'h0);

    // R8 latch while masked, unmask exposes
    wr(8'h28, 32'h28); wr(8'h10, 32'hFFFF_FFFF);
    @(negedge clk); src = 32'h200; idle(2); src = '0; idle(4);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R8 latched masked", d, 32'h200);
    wr(8'h10, ~32'h200); chk("R8 unmask irq", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);

    // R11 synchroniser latency (level mode, unmasked)
    wr(8'h28, 32'h0); wr(8'h10, 32'h0);
    @(negedge clk); src = 32'h80;
    @(negedge clk); @(negedge clk);
    chk("R11 after 2 edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 after 3 edges", {31'b0, irq}, 32'h1);
    src = '0; idle(4); wr(8'h00, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule